// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits between a byte-wide write bus and the control logic of a parallel nonvolatile memory. It watches every write that has already been brought into the local clock domain and recognises the multi-cycle unlock sequences that guard the memory's alteration commands. Every sequence opens with two fixed key writes. A three-write form then picks page write under protection, identification entry or identification exit. A six-write form repeats the keys and picks protection removal, chip erase or an alternate identification entry.

Each recognised command leaves the block as a single-cycle pulse. The block also holds two flags: a global write-protection flag and an identification-mode flag. It gates ordinary data writes toward the array according to the protection state. While identification mode is active it places two fixed identity bytes on the read path in place of array data. A `busy` input from the program timer freezes the decoder and closes any open page-write window.

Top module: `unlock_seq_decoder`

## Requirements
- R1: After a synchronous reset all command pulses are low, the protection flag is 0 (unprotected), the identification flag is 0, and read data equals the array data.
- R2: The writes AAh@5555h, 55h@2AAAh, A0h@5555h produce one `cmd_prot_wr` pulse and set `prot_on` to 1. Repeating the sequence while protected pulses again and leaves the flag at 1.
- R3: The writes AAh@5555h, 55h@2AAAh, then 90h@5555h pulse `cmd_id_in` and set `id_mode` to 1. The same two keys followed by F0h@5555h pulse `cmd_id_out` and clear `id_mode` to 0.
- R4: The six writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h pulse `cmd_unprot` and clear `prot_on` to 0.
- R5: The six-write form ending in 10h@5555h pulses `cmd_erase` and changes neither flag.
- R6: The six-write form ending in 60h@5555h pulses `cmd_id_in` and sets `id_mode` to 1.
- R7: While `id_mode` is 1 and `rd_addr[14:1]` is zero, `rd_data` is BFh when `rd_addr[0]` is 0 and 5Dh when it is 1. Any other address, or `id_mode` 0, returns `arr_rdata`.
- R8: A write that does not match the expected step of a sequence returns the decoder to idle with no pulse. A later lone key or command byte then has no effect.
- R9: A command pulse is high only in the cycle after the clock edge that samples the final write. It lasts one cycle, and at most one command pulse is high at a time.
- R10: While `busy` is 1, sampled writes are ignored: no pulse, no sequence progress, no forwarded write. `busy` also closes the page-write window.
- R11: With `prot_on` 0, an idle-state data write is forwarded on `arr_wr_en`. With `prot_on` 1 it is forwarded only while the page-write window opened by R2 is still open.
- R12: Writes consumed by the decoder are never forwarded. This covers the opening AAh@5555h and every write taken while a sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | One-cycle strobe marking a sampled bus write |
| wr_addr | input | 15 | Write address (bit 15 of the bus already removed) |
| wr_data | input | 8 | Write data |
| busy | input | 1 | Program/erase timer running; writes are ignored |
| rd_addr | input | 15 | Read address |
| arr_rdata | input | 8 | Data read from the array |
| rd_data | output | 8 | Read data after the identification mux |
| arr_wr_en | output | 1 | Forward the current write to the page buffer |
| prot_on | output | 1 | Global write protection enabled |
| id_mode | output | 1 | Identification mode active |
| cmd_prot_wr | output | 1 | Pulse: protect and open a page write |
| cmd_unprot | output | 1 | Pulse: protection removed |
| cmd_erase | output | 1 | Pulse: chip erase requested |
| cmd_id_in | output | 1 | Pulse: identification mode entered |
| cmd_id_out | output | 1 | Pulse: identification mode left |

## Verification
Two functions can meet in one cycle: a `busy` assertion and the final write of an unlock sequence. Whichever one the decoder honours decides whether a command escapes while the program timer runs. The bench holds `busy` high across a complete three-write sequence. It then checks that no pulse appears, that the protection flag does not move and that nothing is forwarded. A second collision pairs a forwarded data write inside an open page-write window with a one-cycle `busy` pulse. The next data write must then be blocked.

// File: rtl/ucd_pkg.sv
// Shared constants and types for the unlock sequence decoder.
// Assumes a 15-bit compared address and byte-wide data.
package ucd_pkg;

    localparam int KEY_W  = 15;
    localparam int DATA_W = 8;

    localparam logic [KEY_W-1:0]  KEY_ODD   = 15'h5555;
    localparam logic [KEY_W-1:0]  KEY_EVEN  = 15'h2AAA;
    localparam logic [DATA_W-1:0] OPEN_BYTE = 8'hAA;
    localparam logic [DATA_W-1:0] SEC_BYTE  = 8'h55;

    // Command byte table; indices below select entries.
    localparam int NCODE = 7;
    localparam int IX_PROT   = 0;
    localparam int IX_IDIN   = 1;
    localparam int IX_IDOUT  = 2;
    localparam int IX_EXT    = 3;
    localparam int IX_UNPROT = 4;
    localparam int IX_ERASE  = 5;
    localparam int IX_ALTID  = 6;
    localparam logic [DATA_W-1:0] CODE_TAB [NCODE] =
        '{8'hA0, 8'h90, 8'hF0, 8'h80, 8'h20, 8'h10, 8'h60};

    typedef enum logic [2:0] {
        ST_IDLE, ST_GOT1, ST_GOT2, ST_EXT, ST_GOT4, ST_GOT5
    } seq_st_t;

    typedef struct packed {
        logic prot_wr;
        logic unprot;
        logic erase;
        logic id_in;
        logic id_out;
    } cmd_t;

endpackage

// File: rtl/ucd_step_match.sv
// Compares one write against the key addresses, key bytes and the
// command byte table. Purely combinational; assumes address already
// stripped to the compared width.
module ucd_step_match
    import ucd_pkg::*;
#(
    parameter int AW = KEY_W,
    parameter int DW = DATA_W,
    parameter int NC = NCODE
) (
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic          at_odd,
    output logic          at_even,
    output logic          is_open,
    output logic          is_second,
    output logic [NC-1:0] code_hit
);

    // Key address and key byte compares.
    always_comb begin
        at_odd    = (addr == AW'(KEY_ODD));
        at_even   = (addr == AW'(KEY_EVEN));
        is_open   = (data == DW'(OPEN_BYTE));
        is_second = (data == DW'(SEC_BYTE));
    end

    // One comparator per command byte.
    for (genvar i = 0; i < NC; i++) begin : g_code
        assign code_hit[i] = (data == DW'(CODE_TAB[i]));
    end

endmodule

// File: rtl/ucd_seq_fsm.sv
// Sequence state machine: walks the three- and six-write unlock forms
// through a shared key front end, emits single-cycle command pulses and
// keeps the protection, identification and page-window flags.
// Assumes wr_stb is a one-cycle strobe in this clock domain.
module ucd_seq_fsm
    import ucd_pkg::*;
#(
    parameter int NC = NCODE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic          busy,
    input  logic          at_odd,
    input  logic          at_even,
    input  logic          is_open,
    input  logic          is_second,
    input  logic [NC-1:0] code_hit,
    output cmd_t          cmd,
    output logic          prot_on,
    output logic          id_mode,
    output logic          page_open,
    output logic          seq_idle
);

    seq_st_t st, st_nxt;
    cmd_t    dec;
    logic    take;

    assign take     = wr_stb && !busy;
    assign seq_idle = (st == ST_IDLE);

    // Next state and command decode for a taken write.
    always_comb begin
        st_nxt = st;
        dec    = '0;
        if (take) begin
            case (st)
                ST_IDLE: if (at_odd && is_open) st_nxt = ST_GOT1;
                ST_GOT1: st_nxt = (at_even && is_second) ? ST_GOT2 : ST_IDLE;
                ST_GOT2: begin
                    st_nxt = ST_IDLE;
                    if (at_odd) begin
                        if (code_hit[IX_PROT])       dec.prot_wr = 1'b1;
                        else if (code_hit[IX_IDIN])  dec.id_in   = 1'b1;
                        else if (code_hit[IX_IDOUT]) dec.id_out  = 1'b1;
                        else if (code_hit[IX_EXT])   st_nxt      = ST_EXT;
                    end
                end
                ST_EXT:  st_nxt = (at_odd && is_open) ? ST_GOT4 : ST_IDLE;
                ST_GOT4: st_nxt = (at_even && is_second) ? ST_GOT5 : ST_IDLE;
                ST_GOT5: begin
                    st_nxt = ST_IDLE;
                    if (at_odd) begin
                        if (code_hit[IX_UNPROT])     dec.unprot = 1'b1;
                        else if (code_hit[IX_ERASE]) dec.erase  = 1'b1;
                        else if (code_hit[IX_ALTID]) dec.id_in  = 1'b1;
                    end
                end
                default: st_nxt = ST_IDLE;
            endcase
        end
    end

    // State register and one-cycle command pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cmd <= '0;
        end else begin
            st  <= st_nxt;
            cmd <= dec;
        end
    end

    // Persistent flags: protection, identification mode, page window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_on   <= 1'b0;
            id_mode   <= 1'b0;
            page_open <= 1'b0;
        end else begin
            if (dec.prot_wr)     prot_on <= 1'b1;
            else if (dec.unprot) prot_on <= 1'b0;
            if (dec.id_in)       id_mode <= 1'b1;
            else if (dec.id_out) id_mode <= 1'b0;
            if (busy)            page_open <= 1'b0;
            else if (dec.prot_wr) page_open <= 1'b1;
        end
    end

    // R9: never two command pulses together.
    a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd));

    // R9: a pulse never lasts two cycles.
    a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != '0) |=> (cmd == '0));

    // R2: protect command leaves protection on.
    a_r2_prot_set: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.prot_wr |-> prot_on);

    // R4: unprotect command leaves protection off.
    a_r4_unprot_clr: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.unprot |-> !prot_on);

    // R3: identification flag follows entry and exit pulses.
    a_r3_id_enter: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.id_in |-> id_mode);
    a_r3_id_leave: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.id_out |-> !id_mode);

    // R10: nothing decoded while busy, and busy closes the page window.
    a_r10_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (cmd == '0));
    a_r10_page_close: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !page_open);

endmodule

// File: rtl/ucd_id_mux.sv
// Read path mux: returns the fixed identity bytes while identification
// mode is active and the low-address window is hit, array data otherwise.
module ucd_id_mux #(
    parameter int          AW     = 15,
    parameter int          DW     = 8,
    parameter logic [7:0]  MFR_ID = 8'hBF,
    parameter logic [7:0]  DEV_ID = 8'h5D
) (
    input  logic          id_mode,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] arr_rdata,
    output logic [DW-1:0] rd_data
);

    logic id_win;

    // Identity window is the two lowest addresses.
    assign id_win = id_mode && (rd_addr[AW-1:1] == '0);

    // Select identity byte or array data.
    always_comb begin
        if (id_win) rd_data = rd_addr[0] ? DW'(DEV_ID) : DW'(MFR_ID);
        else        rd_data = arr_rdata;
    end

endmodule

// File: rtl/unlock_seq_decoder.sv
// Top of the unlock sequence decoder: matcher, sequence machine,
// identification read mux and the array write gate.
// Assumes writes arrive as one-cycle strobes already in this domain and
// that the caller removes address bit 15 before this block.
module unlock_seq_decoder
    import ucd_pkg::*;
#(
    parameter int         AW     = KEY_W,
    parameter int         DW     = DATA_W,
    parameter logic [7:0] MFR_ID = 8'hBF,
    parameter logic [7:0] DEV_ID = 8'h5D
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          busy,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] arr_rdata,
    output logic [DW-1:0] rd_data,
    output logic          arr_wr_en,
    output logic          prot_on,
    output logic          id_mode,
    output logic          cmd_prot_wr,
    output logic          cmd_unprot,
    output logic          cmd_erase,
    output logic          cmd_id_in,
    output logic          cmd_id_out
);

    logic             at_odd, at_even, is_open, is_second;
    logic [NCODE-1:0] code_hit;
    cmd_t             cmd;
    logic             page_open, seq_idle;

    ucd_step_match #(.AW(AW), .DW(DW), .NC(NCODE)) u_match (
        .addr      (wr_addr),
        .data      (wr_data),
        .at_odd    (at_odd),
        .at_even   (at_even),
        .is_open   (is_open),
        .is_second (is_second),
        .code_hit  (code_hit)
    );

    ucd_seq_fsm #(.NC(NCODE)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .busy      (busy),
        .at_odd    (at_odd),
        .at_even   (at_even),
        .is_open   (is_open),
        .is_second (is_second),
        .code_hit  (code_hit),
        .cmd       (cmd),
        .prot_on   (prot_on),
        .id_mode   (id_mode),
        .page_open (page_open),
        .seq_idle  (seq_idle)
    );

    ucd_id_mux #(.AW(AW), .DW(DW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_idmux (
        .id_mode   (id_mode),
        .rd_addr   (rd_addr),
        .arr_rdata (arr_rdata),
        .rd_data   (rd_data)
    );

    // Forward only idle-state non-key writes that protection allows.
    assign arr_wr_en = wr_stb && !busy && seq_idle && !(at_odd && is_open)
                       && (!prot_on || page_open);

    // Break out the command pulses.
    assign cmd_prot_wr = cmd.prot_wr;
    assign cmd_unprot  = cmd.unprot;
    assign cmd_erase   = cmd.erase;
    assign cmd_id_in   = cmd.id_in;
    assign cmd_id_out  = cmd.id_out;

    // R11: a forwarded data write never completes a command.
    a_r11_fwd_not_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_en |=> (cmd == '0));

    // R11: a protected array sees writes only through the page window.
    a_r11_prot_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_en && prot_on) |-> page_open);

endmodule

// File: tb/unlock_seq_decoder_test.sv
// Self-checking bench for unlock_seq_decoder: a vector table walked by one
// loop, then directed tests for reset, reads, breaks, busy and gating.
module unlock_seq_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        busy = 1'b0;
    logic [14:0] rd_addr = '0;
    logic [7:0]  arr_rdata = 8'h3C;
    logic [7:0]  rd_data;
    logic        arr_wr_en, prot_on, id_mode;
    logic        cmd_prot_wr, cmd_unprot, cmd_erase, cmd_id_in, cmd_id_out;

    int total = 0;
    int bad = 0;
    logic last_fwd = 1'b0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    unlock_seq_decoder uut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .rd_addr(rd_addr),
        .arr_rdata(arr_rdata), .rd_data(rd_data), .arr_wr_en(arr_wr_en),
        .prot_on(prot_on), .id_mode(id_mode), .cmd_prot_wr(cmd_prot_wr),
        .cmd_unprot(cmd_unprot), .cmd_erase(cmd_erase),
        .cmd_id_in(cmd_id_in), .cmd_id_out(cmd_id_out)
    );

    function automatic logic [4:0] pulses();
        return {cmd_prot_wr, cmd_unprot, cmd_erase, cmd_id_in, cmd_id_out};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One write strobe; returns at the next falling edge, after the sampling edge.
    task automatic wr(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_addr = a; wr_data = d; wr_stb = 1'b1;
        #1 last_fwd = arr_wr_en;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // {addr[29:15], data[14:7], pulses[6:2] (prot_wr,unprot,erase,id_in,id_out), prot[1], id[0]}
    localparam int NV = 30;
    localparam logic [29:0] VEC [NV] = '{
        {15'h5555, 8'hAA, 5'b00000, 1'b0, 1'b0},
        {15'h2AAA, 8'h55, 5'b00000, 1'b0, 1'b0},
        {15'h5555, 8'hA0, 5'b10000, 1'b1, 1'b0},  // R2
        {15'h5555, 8'hAA, 5'b00000, 1'b1, 1'b0},
        {15'h2AAA, 8'h55, 5'b00000, 1'b1, 1'b0},
        {15'h5555, 8'h90, 5'b00010, 1'b1, 1'b1},  // R3 entry
        {15'h5555, 8'hAA, 5'b00000, 1'b1, 1'b1},
        {15'h2AAA, 8'h55, 5'b00000, 1'b1, 1'b1},
        {15'h5555, 8'hF0, 5'b00001, 1'b1, 1'b0},  // R3 exit
        {15'h5555, 8'hAA, 5'b00000, 1'b1, 1'b0},
        {15'h2AAA, 8'h55, 5'b00000, 1'b1, 1'b0},
        {15'h5555, 8'h80, 5'b00000, 1'b1, 1'b0},
        {15'h5555, 8'hAA, 5'b00000, 1'b1, 1'b0},
        {15'h2AAA, 8'h55, 5'b00000, 1'b1, 1'b0},
        {15'h5555, 8'h20, 5'b01000, 1'b0, 1'b0},  // R4
        {15'h5555, 8'hAA, 5'b00000, 1'b0, 1'b0},
        {15'h2AAA, 8'h55, 5'b00000, 1'b0, 1'b0},
        {15'h5555, 8'h80, 5'b00000, 1'b0, 1'b0},
        {15'h5555, 8'hAA, 5'b00000, 1'b0, 1'b0},
        {15'h2AAA, 8'h55, 5'b00000, 1'b0, 1'b0},
        {15'h5555, 8'h10, 5'b00100, 1'b0, 1'b0},  // R5
        {15'h5555, 8'hAA, 5'b00000, 1'b0, 1'b0},
        {15'h2AAA, 8'h55, 5'b00000, 1'b0, 1'b0},
        {15'h5555, 8'h80, 5'b00000, 1'b0, 1'b0},
        {15'h5555, 8'hAA, 5'b00000, 1'b0, 1'b0},
        {15'h2AAA, 8'h55, 5'b00000, 1'b0, 1'b0},
        {15'h5555, 8'h60, 5'b00010, 1'b0, 1'b1},  // R6
        {15'h5555, 8'hAA, 5'b00000, 1'b0, 1'b1},
        {15'h2AAA, 8'h55, 5'b00000, 1'b0, 1'b1},
        {15'h5555, 8'hF0, 5'b00001, 1'b0, 1'b0}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 pulses", int'(pulses()), 0);
        chk("R1 prot_on", int'(prot_on), 0);
        chk("R1 id_mode", int'(id_mode), 0);
        chk("R1 rd_data", int'(rd_data), 'h3C);

        // Table walk: R2 R3 R4 R5 R6 and R9 pulse timing
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][29:15], VEC[i][14:7]);
            chk($sformatf("R9 pulses step %0d", i), int'(pulses()), int'(VEC[i][6:2]));
            chk($sformatf("R2 prot flag step %0d", i), int'(prot_on), int'(VEC[i][1]));
            chk($sformatf("R3 id flag step %0d", i), int'(id_mode), int'(VEC[i][0]));
        end
        @(negedge clk);
        chk("R9 pulse width", int'(pulses()), 0);

        // R7: identity read mux
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h90);
        rd_addr = 15'h0000; #1;
        chk("R7 mfr byte", int'(rd_data), 'hBF);
        rd_addr = 15'h0001; #1;
        chk("R7 dev byte", int'(rd_data), 'h5D);
        rd_addr = 15'h0002; #1;
        chk("R7 outside window", int'(rd_data), 'h3C);
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'hF0);
        rd_addr = 15'h0000; #1;
        chk("R7 after exit", int'(rd_data), 'h3C);

        // R11 / R12: forwarding while unprotected
        wr(15'h0100, 8'h33);
        chk("R11 unprotected forward", int'(last_fwd), 1);
        wr(15'h5555, 8'hAA);
        chk("R12 opener held", int'(last_fwd), 0);
        wr(15'h2AAA, 8'h55);
        chk("R12 key held", int'(last_fwd), 0);
        wr(15'h0100, 8'h77);
        chk("R12 in-sequence held", int'(last_fwd), 0);
        chk("R8 break no pulse", int'(pulses()), 0);

        // R8: broken second step then stray tail
        wr(15'h5555, 8'hAA);
        wr(15'h1234, 8'h12);
        chk("R8 break pulses", int'(pulses()), 0);
        wr(15'h2AAA, 8'h55);
        wr(15'h5555, 8'hA0);
        chk("R8 stray tail pulses", int'(pulses()), 0);
        chk("R8 stray tail prot", int'(prot_on), 0);

        // R10: sequence under busy is ignored
        @(negedge clk); busy = 1'b1;
        wr(15'h5555, 8'hAA);
        chk("R10 busy no forward", int'(last_fwd), 0);
        wr(15'h2AAA, 8'h55); wr(15'h5555, 8'hA0);
        chk("R10 busy pulses", int'(pulses()), 0);
        chk("R10 busy prot", int'(prot_on), 0);
        wr(15'h0100, 8'h55);
        chk("R10 busy data not forwarded", int'(last_fwd), 0);
        @(negedge clk); busy = 1'b0;

        // R11: page window under protection
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'hA0);
        chk("R2 protect pulse", int'(cmd_prot_wr), 1);
        wr(15'h0100, 8'h11);
        chk("R11 window forward", int'(last_fwd), 1);
        @(negedge clk); busy = 1'b1;
        @(negedge clk); busy = 1'b0;
        wr(15'h0100, 8'h22);
        chk("R11 protected blocked", int'(last_fwd), 0);
        chk("R11 prot kept", int'(prot_on), 1);

        // R1: reset clears both flags
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h90);
        chk("R3 id set before reset", int'(id_mode), 1);
        do_reset();
        #1;
        chk("R1 prot after reset", int'(prot_on), 0);
        chk("R1 id after reset", int'(id_mode), 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(4 * 20000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule